// File: doc/BRIEF.md
# Pretrigger Capture Sequencer

This block runs one oscilloscope acquisition into a circular sample store of 1024 words. Once it is armed it first collects a programmable number of samples that come before the trigger point. It then keeps recording while it waits for a trigger. After a trigger it records exactly enough further samples to fill the rest of the store. The store then holds the 1024 most recent samples, with the trigger point at the requested position.

When a capture is complete, a host raises the read-mode level. The block then steps through the store from the oldest sample to the newest, advancing one entry per read strobe. After the last entry has been delivered, the block parks and waits for a soft reset or a fresh arm.

Every phase has its own 4-bit status code on the status port. Trigger detection, host transport and sample-rate generation sit outside this block and reach it as strobes and pulses.

Top module: `cap_ctrl`

## Requirements
- R1: The status port encodes the phase as follows: 0 idle after reset, 1 waiting for arm, 2 armed, 3 pretrigger filling, 4 pretrigger full and waiting for trigger, 5 post-trigger filling, 6 complete and waiting for read, 7 reading, 8 read finished. While rst_n is low the status is 0, and on the first clock after release it becomes 1.
- R2: A one-clock fsm_rst_p pulse forces status 0 on the next clock from any phase, and status 1 follows on the clock after that.
- R3: An arm_p pulse while the status is 1 or 8 and read_mode is 0 gives status 2 on the next clock and status 3 on the clock after. The trig_pos value is captured with the arm. The arm is ignored when read_mode is 1 or when the status is any other code.
- R4: In status 3 each smp_en strobe stores smp_word. Once the count of stored samples since the arm equals the pretrigger length, the status becomes 4 on the next clock. A length of 0 keeps status 3 for exactly one clock.
- R5: trig_evt and force_trig_p have no effect in any status other than 4, including while the pretrigger region is still filling.
- R6: In status 4, samples keep being stored. A trig_evt or force_trig_p pulse gives status 5 on the next clock.
- R7: In status 5 the status becomes 6 on the clock that stores the (1024 − pretrigger length)-th sample after the trigger. capture_done is 1 exactly while the status is 6.
- R8: The stored word layout is bits 9:0 first analog sample, bits 19:10 second analog sample, bits 27:20 logic inputs and bit 28 status bit. Bits 31:29 always read back as 0, whatever was driven.
- R9: In status 6, read_mode = 1 gives status 7 on the next clock, and the read pointer is placed at the oldest stored sample. rd_data shows the entry under the read pointer one clock after the pointer moves. Reading yields the last 1024 stored samples in the order they were stored.
- R10: In status 7 each rd_stb advances the read pointer by one entry, modulo 1024. The strobe that consumes the 1024th entry gives status 8. rd_stb has no effect in other phases, and without a strobe status 7 is held.
- R11: A trig_pos above 1023 is treated as a pretrigger length of 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample-valid strobe |
| smp_word | input | 32 | Packed sample word |
| trig_evt | input | 1 | Trigger-event pulse from the detector |
| trig_pos | input | 16 | Requested pretrigger length, captured at arm |
| fsm_rst_p | input | 1 | Soft reset pulse |
| arm_p | input | 1 | Arm pulse |
| force_trig_p | input | 1 | Forced-trigger pulse |
| read_mode | input | 1 | 1 selects readback, 0 selects acquisition |
| rd_stb | input | 1 | Advance-read strobe |
| status | output | 4 | Phase code |
| capture_done | output | 1 | High while a finished capture waits for readback |
| rd_data | output | 32 | Entry under the read pointer, registered |

## Verification
Every status change is due on the first clock edge after the pulse, strobe or fill count that causes it, because the phase register is the only register in that path. rd_data comes two edges after a read strobe: one edge moves the pointer and the next loads the data register. The bench drives inputs just after a falling edge and reads results at the following falling edge. Each check is placed after exactly the number of edges its path has, so a shifted transition shows up as a mismatch and is not absorbed by polling.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [3:0] {
    ST_RESET     = 4'd0,
    ST_WAIT_ARM  = 4'd1,
    ST_ARMED     = 4'd2,
    ST_PRE_FILL  = 4'd3,
    ST_WAIT_TRIG = 4'd4,
    ST_POST_FILL = 4'd5,
    ST_DONE      = 4'd6,
    ST_READING   = 4'd7,
    ST_READ_END  = 4'd8
  } cap_state_e;

  // pretrigger length: requested position limited to one less than the depth
  function automatic int unsigned pre_len(int unsigned pos, int unsigned depth);
    return (pos >= depth) ? depth - 1 : pos;
  endfunction

  // samples still owed after the trigger so that the store is exactly full
  function automatic int unsigned post_len(int unsigned pre, int unsigned depth);
    return depth - pre;
  endfunction

  // mask that keeps the meaningful low bits of a stored word
  function automatic logic [63:0] keep_mask(int unsigned used_w);
    return (64'd1 << used_w) - 64'd1;
  endfunction

endpackage

// File: rtl/cap_seq_fsm.sv
module cap_seq_fsm
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsm_rst_p,
  input  logic       arm_p,
  input  logic       trig_p,
  input  logic       force_p,
  input  logic       read_mode,
  input  logic       smp_en,
  input  logic       rd_stb,
  input  logic       pre_full,
  input  logic       post_last,
  input  logic       rd_last,
  output cap_state_e state,
  output logic       ev_arm,
  output logic       ev_trig,
  output logic       ev_wr,
  output logic       ev_rd_start,
  output logic       ev_rd
);

  cap_state_e nxt;
  logic       live;
  logic       in_fill;

  assign live    = ~fsm_rst_p;
  assign in_fill = (state == ST_PRE_FILL) || (state == ST_WAIT_TRIG) ||
                   (state == ST_POST_FILL);

  // accepted events, named so the checker and the counters share them
  assign ev_arm      = live & arm_p & ~read_mode &
                       ((state == ST_WAIT_ARM) || (state == ST_READ_END));
  assign ev_trig     = live & (trig_p | force_p) & (state == ST_WAIT_TRIG);
  assign ev_wr       = live & smp_en & in_fill;
  assign ev_rd_start = live & read_mode & (state == ST_DONE);
  assign ev_rd       = live & rd_stb & (state == ST_READING);

  always_comb begin
    nxt = state;
    if (fsm_rst_p) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET:     nxt = ST_WAIT_ARM;
        ST_WAIT_ARM,
        ST_READ_END:  if (ev_arm) nxt = ST_ARMED;
        ST_ARMED:     nxt = ST_PRE_FILL;
        ST_PRE_FILL:  if (pre_full) nxt = ST_WAIT_TRIG;
        ST_WAIT_TRIG: if (ev_trig) nxt = ST_POST_FILL;
        ST_POST_FILL: if (post_last) nxt = ST_DONE;
        ST_DONE:      if (ev_rd_start) nxt = ST_READING;
        ST_READING:   if (rd_last) nxt = ST_READ_END;
        default:      nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

endmodule

// File: rtl/cap_ptr_unit.sv
module cap_ptr_unit #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arm,
  input  logic              ev_trig,
  input  logic              ev_wr,
  input  logic              ev_rd_start,
  input  logic              ev_rd,
  input  logic [POS_W-1:0]  trig_pos,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              pre_full,
  output logic              post_last,
  output logic              rd_last
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned CNT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] rd_cnt;
  logic [ADDR_W-1:0] pre_tgt;
  logic [CNT_W-1:0]  post_tgt;
  logic [CNT_W-1:0]  fill_cnt;
  logic [CNT_W-1:0]  fill_inc;
  int unsigned       pre_req;

  assign pre_req  = cap_pkg::pre_len(32'(trig_pos), DEPTH);
  assign fill_inc = fill_cnt + CNT_W'(1);

  // targets and fill counter: arm clears, trigger restarts, writes count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_tgt  <= '0;
      post_tgt <= CNT_W'(DEPTH);
      fill_cnt <= '0;
    end else if (ev_arm) begin
      pre_tgt  <= ADDR_W'(pre_req);
      post_tgt <= CNT_W'(cap_pkg::post_len(pre_req, DEPTH));
      fill_cnt <= '0;
    end else if (ev_trig) begin
      fill_cnt <= '0;
    end else if (ev_wr) begin
      fill_cnt <= fill_inc;
    end
  end

  // circular write pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (ev_arm)  wr_ptr <= '0;
    else if (ev_wr)   wr_ptr <= wr_ptr + ADDR_W'(1);
  end

  // read pointer starts at the oldest entry, i.e. the next write slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      rd_cnt <= '0;
    end else if (ev_rd_start) begin
      rd_ptr <= wr_ptr;
      rd_cnt <= '0;
    end else if (ev_rd) begin
      rd_ptr <= rd_ptr + ADDR_W'(1);
      rd_cnt <= rd_cnt + ADDR_W'(1);
    end
  end

  assign pre_full  = (fill_cnt == {1'b0, pre_tgt});
  assign post_last = ev_wr & (fill_inc == post_tgt);
  assign rd_last   = ev_rd & (rd_cnt == {ADDR_W{1'b1}});
  assign wr_addr   = wr_ptr;
  assign rd_addr   = rd_ptr;

endmodule

// File: rtl/cap_sample_ram.sv
module cap_sample_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned USED_W = 29
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned     DEPTH = 1 << ADDR_W;
  localparam logic [WORD_W-1:0] KEEP = WORD_W'(cap_pkg::keep_mask(USED_W));

  logic [WORD_W-1:0] mem [DEPTH];

  // pad bits are dropped on the way in
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata & KEEP;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned USED_W = 29,
  parameter int unsigned POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              trig_evt,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic              fsm_rst_p,
  input  logic              arm_p,
  input  logic              force_trig_p,
  input  logic              read_mode,
  input  logic              rd_stb,
  output logic [3:0]        status,
  output logic              capture_done,
  output logic [WORD_W-1:0] rd_data
);

  import cap_pkg::*;

  cap_state_e        state;
  logic              ev_arm;
  logic              ev_trig;
  logic              ev_wr;
  logic              ev_rd_start;
  logic              ev_rd;
  logic              pre_full;
  logic              post_last;
  logic              rd_last;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  cap_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsm_rst_p   (fsm_rst_p),
    .arm_p       (arm_p),
    .trig_p      (trig_evt),
    .force_p     (force_trig_p),
    .read_mode   (read_mode),
    .smp_en      (smp_en),
    .rd_stb      (rd_stb),
    .pre_full    (pre_full),
    .post_last   (post_last),
    .rd_last     (rd_last),
    .state       (state),
    .ev_arm      (ev_arm),
    .ev_trig     (ev_trig),
    .ev_wr       (ev_wr),
    .ev_rd_start (ev_rd_start),
    .ev_rd       (ev_rd)
  );

  cap_ptr_unit #(
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_arm      (ev_arm),
    .ev_trig     (ev_trig),
    .ev_wr       (ev_wr),
    .ev_rd_start (ev_rd_start),
    .ev_rd       (ev_rd),
    .trig_pos    (trig_pos),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .pre_full    (pre_full),
    .post_last   (post_last),
    .rd_last     (rd_last)
  );

  cap_sample_ram #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .USED_W (USED_W)
  ) u_ram (
    .clk   (clk),
    .we    (ev_wr),
    .waddr (wr_addr),
    .wdata (smp_word),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign status       = state;
  assign capture_done = (state == ST_DONE);

endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fsm_rst_p,
  input logic       rd_stb,
  input logic       ev_wr,
  input logic [3:0] status,
  input logic       capture_done
);

  // R1: only the nine defined codes appear
  a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 4'd8);

  // R2: soft reset lands in code 0
  a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst_p |=> status == 4'd0);

  // R3: armed lasts one clock
  a_r3_armed_once: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd2 && !fsm_rst_p) |=> status == 4'd3);

  // R5: no jump from pretrigger fill to post-trigger fill
  a_r5_no_early_trig: assert property (@(posedge clk) disable iff (!rst_n)
    status == 4'd3 |=> status != 4'd5);

  // R7: completion only on a stored sample
  a_r7_done_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd5 && !ev_wr && !fsm_rst_p) |=> status == 4'd5);

  // R7: capture_done rises only out of the post-trigger fill
  a_r7_done_flag_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_done) |-> $past(status) == 4'd5);

  // R10: reading is held while no strobe arrives
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 4'd7 && !rd_stb && !fsm_rst_p) |=> status == 4'd7);

  // R10: read-finished is reached only from reading
  a_r10_end_entry: assert property (@(posedge clk) disable iff (!rst_n)
    status == 4'd8 |-> ($past(status) == 4'd7 || $past(status) == 4'd8));

endmodule

bind cap_ctrl cap_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fsm_rst_p    (fsm_rst_p),
  .rd_stb       (rd_stb),
  .ev_wr        (ev_wr),
  .status       (status),
  .capture_done (capture_done)
);

// File: tb/cap_ctrl_tb_top.sv
`timescale 1ns/1ps
module cap_ctrl_tb_top;

  localparam int unsigned DEPTH = 1024;
  localparam int unsigned NVEC  = 5;
  localparam int unsigned WD_CYCLES = 150000;
  // table: requested position, samples before trigger, use forced trigger
  localparam int unsigned VEC_POS  [NVEC] = '{0, 100, 1023, 5000, 512};
  localparam int unsigned VEC_WAIT [NVEC] = '{3, 0, 5, 2, 1500};
  localparam int unsigned VEC_FRC  [NVEC] = '{0, 1, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_en;
  logic [31:0] smp_word;
  logic        trig_evt;
  logic [15:0] trig_pos;
  logic        fsm_rst_p;
  logic        arm_p;
  logic        force_trig_p;
  logic        read_mode;
  logic        rd_stb;
  logic [3:0]  status;
  logic        capture_done;
  logic [31:0] rd_data;

  int unsigned checks = 0;
  int unsigned fails  = 0;

  always #2.5 clk = ~clk;

  cap_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_en       (smp_en),
    .smp_word     (smp_word),
    .trig_evt     (trig_evt),
    .trig_pos     (trig_pos),
    .fsm_rst_p    (fsm_rst_p),
    .arm_p        (arm_p),
    .force_trig_p (force_trig_p),
    .read_mode    (read_mode),
    .rd_stb       (rd_stb),
    .status       (status),
    .capture_done (capture_done),
    .rd_data      (rd_data)
  );

  function automatic logic [31:0] word_of(int unsigned n);
    logic [31:0] h;
    h = n * 32'd2654435761;
    return {3'b111, h[28:0] ^ 29'(n)};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual=%0d cycles expected=fewer", WD_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_en = 1'b0; smp_word = '0; trig_evt = 1'b0;
    trig_pos = '0; fsm_rst_p = 1'b0; arm_p = 1'b0; force_trig_p = 1'b0;
    read_mode = 1'b0; rd_stb = 1'b0;
    repeat (3) cyc();
    chk("R1", 32'(status), 32'd0, "status in reset");
    rst_n = 1'b1;
    cyc();
    chk("R1", 32'(status), 32'd1, "status after release");

    // R5: trigger and forced trigger while waiting for arm
    trig_evt = 1'b1; force_trig_p = 1'b1; cyc();
    trig_evt = 1'b0; force_trig_p = 1'b0; cyc();
    chk("R5", 32'(status), 32'd1, "trigger before arm");
    // R3: arm refused in readback mode
    read_mode = 1'b1; arm_p = 1'b1; cyc();
    arm_p = 1'b0; read_mode = 1'b0;
    chk("R3", 32'(status), 32'd1, "arm with read_mode=1");
    // R10: read strobe outside reading
    rd_stb = 1'b1; cyc(); rd_stb = 1'b0;
    chk("R10", 32'(status), 32'd1, "strobe while idle");

    for (int v = 0; v < NVEC; v++) begin
      int unsigned p;
      int unsigned n;
      int unsigned w;
      string       r4tag;
      p = (VEC_POS[v] > DEPTH - 1) ? DEPTH - 1 : VEC_POS[v];
      w = VEC_WAIT[v];
      r4tag = (VEC_POS[v] > DEPTH - 1) ? "R11" : "R4";
      n = 0;
      trig_pos = 16'(VEC_POS[v]);
      arm_p = 1'b1; cyc(); arm_p = 1'b0;
      chk("R3", 32'(status), 32'd2, "armed");
      trig_pos = ~trig_pos;
      cyc();
      chk("R3", 32'(status), 32'd3, "pretrigger fill entered");
      for (int i = 0; i < int'(p); i++) begin
        smp_en = 1'b1; smp_word = word_of(n); n++;
        trig_evt = (i == int'(p / 2));
        cyc();
      end
      smp_en = 1'b0; trig_evt = 1'b0;
      chk("R5", 32'(status), 32'd3, "trigger ignored in pretrigger fill");
      cyc();
      chk(r4tag, 32'(status), 32'd4, "pretrigger full");
      for (int i = 0; i < int'(w); i++) begin
        smp_en = 1'b1; smp_word = word_of(n); n++; cyc();
      end
      smp_en = 1'b0;
      chk("R6", 32'(status), 32'd4, "waiting while samples stream");
      if (VEC_FRC[v] != 0) force_trig_p = 1'b1; else trig_evt = 1'b1;
      cyc();
      force_trig_p = 1'b0; trig_evt = 1'b0;
      chk("R6", 32'(status), 32'd5, "trigger taken");
      for (int i = 0; i < int'(DEPTH - p - 1); i++) begin
        smp_en = 1'b1; smp_word = word_of(n); n++; cyc();
      end
      smp_en = 1'b0;
      chk("R7", 32'(status), 32'd5, "one sample short of complete");
      chk("R7", 32'(capture_done), 32'd0, "done flag before completion");
      smp_en = 1'b1; smp_word = word_of(n); n++; cyc();
      smp_en = 1'b0;
      chk("R7", 32'(status), 32'd6, "complete");
      chk("R7", 32'(capture_done), 32'd1, "done flag");
      read_mode = 1'b1; cyc();
      chk("R9", 32'(status), 32'd7, "reading entered");
      chk("R7", 32'(capture_done), 32'd0, "done flag in reading");
      cyc();
      for (int i = 0; i < int'(DEPTH); i++) begin
        chk((i == 0) ? "R9" : "R8", rd_data, word_of(n - DEPTH + i) & 32'h1FFF_FFFF,
            $sformatf("vector %0d entry %0d", v, i));
        rd_stb = 1'b1; cyc(); rd_stb = 1'b0; cyc();
      end
      chk("R10", 32'(status), 32'd8, "read finished");
      if (v == 0) begin
        arm_p = 1'b1; cyc(); arm_p = 1'b0;
        chk("R3", 32'(status), 32'd8, "arm refused while read_mode=1");
      end
      read_mode = 1'b0;
    end

    // R2: soft reset in the middle of a pretrigger fill
    trig_pos = 16'd50;
    arm_p = 1'b1; cyc(); arm_p = 1'b0; cyc();
    for (int i = 0; i < 4; i++) begin
      smp_en = 1'b1; smp_word = word_of(i); cyc();
    end
    smp_en = 1'b0;
    chk("R2", 32'(status), 32'd3, "still filling before soft reset");
    fsm_rst_p = 1'b1; cyc(); fsm_rst_p = 1'b0;
    chk("R2", 32'(status), 32'd0, "soft reset");
    cyc();
    chk("R2", 32'(status), 32'd1, "back to waiting for arm");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule